// File: doc/BRIEF.md
# Wavefront Lane Shuffler

This block moves 32-bit operands between the 64 lanes of a wavefront before they reach an arithmetic unit. Every lane produces one of two things: a value taken from another lane under a chosen sharing pattern, or the lane's old destination value. The lanes form four rows of sixteen. Inside each row there are four banks of four lanes. The patterns cover:

- quad permutes
- shifts and rotates within a row
- single-lane shifts and rotates across the whole wave
- row and half-row mirrors
- two broadcasts that carry the last lane of a row into later rows

Two masks gate which lanes may be written: a row mask and a bank mask. A bound-control flag decides what a lane receives when its source lane is outside the pattern's range or is marked invalid. With the flag set the lane receives zero; with it clear the lane keeps its old value.

A caller presents the source vector, the old destination vector, the pattern code, the pattern argument, the masks and the per-lane valid mask, then raises `start` for one cycle. The shuffled vector is registered on that edge. It appears together with a one-cycle `done` pulse and holds until the next start.

Top module: `lane_shuffler`

## Requirements
- R1: `result` and `done` update on the clock edge that samples `start` high; `done` is high for exactly the cycle after each start, and `result` keeps its value while `start` is low.
- R2: After reset, `done` is 0 and `result` is all zeros.
- R3: Lane g has row index g[5:4] and bank index g[3:2]. When `row_mask` bit for its row or `bank_mask` bit for its bank is 0, the lane returns its old value regardless of pattern, validity or bound control.
- R4: Code 0 (quad permute): the lane at position k=g[1:0] of its group of four reads lane (g & ~3) + arg[2k+1:2k].
- R5: Codes 1 and 2 (row shift left / right by n=arg[3:0]): lane i of a row reads row lane i+n (code 1) or i-n (code 2). A source beyond the row's ends is out of range.
- R6: Code 3 (row rotate right by n=arg[3:0]): lane i of a row reads row lane (i-n) mod 16 and is never out of range.
- R7: Codes 4 to 7 act on the whole wave. Code 4 makes lane g read g+1, with lane 63 out of range. Code 5 reads (g+1) mod 64. Code 6 reads g-1, with lane 0 out of range. Code 7 reads (g-1) mod 64.
- R8: Code 8 makes lane i of a row read row lane 15-i. Code 9 makes lane i read row lane i XOR 7 (mirror within each half row).
- R9: Code 10 makes each row r ≥ 1 read lane 16r-1, while row 0 keeps its old value. Code 11 makes rows 2 and 3 read lane 31, while rows 0 and 1 keep their old value. A kept lane is unaffected by bound control.
- R10: A lane whose source is out of range, or whose source lane has its `lane_valid` bit at 0, returns zero when `bound_zero` is 1 and its old value when `bound_zero` is 0. Codes 12 to 15 treat every lane's source as out of range.
- R11: Validity is taken from the source lane's `lane_valid` bit, never the destination's own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture request, one cycle |
| mode | input | 4 | Pattern code |
| arg | input | 8 | Quad selectors or shift amount |
| row_mask | input | 4 | Row write enables |
| bank_mask | input | 4 | Bank write enables |
| bound_zero | input | 1 | Return zero for an unusable source |
| lane_valid | input | 64 | Per-lane source validity |
| src_vec | input | 2048 | Source operands, lane g at bits [32g+31:32g] |
| old_vec | input | 2048 | Old destination values, same layout |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2048 | Shuffled vector, same layout |

## Verification
The hardest case to reach is when out-of-range sources, invalid source lanes, masked-off destinations and broadcast-skipped rows all apply in one operation. Each of these rules has its own precedence. The directed tasks reach this case by giving every lane a distinct source and old value, so that any wrong choice shows up as a wrong value. Each boundary pattern runs with bound control both set and clear. One run uses a valid mask where the source and destination bits disagree, so that taking validity from the wrong lane changes the result. The mask tasks clear single rows and banks in combination with broadcast codes, so the precedence of masking over both the skip rule and the zero rule can be seen at the outputs.

// File: rtl/lane_shuf_pkg.sv
package lane_shuf_pkg;

   typedef enum logic [3:0] {
      SH_QPERM      = 4'd0,
      SH_ROW_SHL    = 4'd1,
      SH_ROW_SHR    = 4'd2,
      SH_ROW_ROR    = 4'd3,
      SH_WAVE_SHL   = 4'd4,
      SH_WAVE_ROL   = 4'd5,
      SH_WAVE_SHR   = 4'd6,
      SH_WAVE_ROR   = 4'd7,
      SH_MIRROR     = 4'd8,
      SH_HALF_MIRR  = 4'd9,
      SH_BCAST_ROW  = 4'd10,
      SH_BCAST_WAVE = 4'd11,
      SH_RSV12      = 4'd12,
      SH_RSV13      = 4'd13,
      SH_RSV14      = 4'd14,
      SH_RSV15      = 4'd15
   } shuf_mode_e;

endpackage

// File: rtl/lane_src_calc.sv
module lane_src_calc
   import lane_shuf_pkg::*;
#(
   parameter int ROWS       = 4,
   parameter int ROW_LANES  = 16,
   parameter int BANK_LANES = 4,
   parameter int ARG_W      = 8,
   localparam int LANES     = ROWS * ROW_LANES,
   localparam int IDX_W     = $clog2(LANES)
) (
   input  logic [3:0]             mode,
   input  logic [ARG_W-1:0]       arg,
   output logic [LANES*IDX_W-1:0] src_idx,
   output logic [LANES-1:0]       src_oor,
   output logic [LANES-1:0]       keep_old
);
   localparam int AMT_W = $clog2(ROW_LANES);
   localparam int SEL_W = $clog2(BANK_LANES);

   shuf_mode_e           m;
   logic [AMT_W-1:0]     amt;

   assign m   = shuf_mode_e'(mode);
   assign amt = arg[AMT_W-1:0];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int R    = g / ROW_LANES;
      localparam int I    = g % ROW_LANES;
      localparam int BASE = R * ROW_LANES;
      localparam int Q    = g % BANK_LANES;
      localparam logic [AMT_W-1:0] I_V = AMT_W'(I);

      logic [IDX_W-1:0] idx;
      logic             oor;
      logic             skip;
      logic [AMT_W:0]   sum;
      logic [AMT_W:0]   dif;

      assign sum = {1'b0, I_V} + {1'b0, amt};
      assign dif = {1'b0, I_V} - {1'b0, amt};

      always_comb begin
         idx  = IDX_W'(g);
         oor  = 1'b0;
         skip = 1'b0;
         unique case (m)
            SH_QPERM:
               idx = IDX_W'(g - Q) + IDX_W'(arg[SEL_W*Q +: SEL_W]);
            SH_ROW_SHL: begin
               oor = sum[AMT_W];
               idx = IDX_W'(BASE) + IDX_W'(sum[AMT_W-1:0]);
            end
            SH_ROW_SHR: begin
               oor = dif[AMT_W];
               idx = IDX_W'(BASE) + IDX_W'(dif[AMT_W-1:0]);
            end
            SH_ROW_ROR:
               idx = IDX_W'(BASE) + IDX_W'(dif[AMT_W-1:0]);
            SH_WAVE_SHL: begin
               oor = (g == LANES - 1);
               idx = IDX_W'(g + 1);
            end
            SH_WAVE_ROL:
               idx = IDX_W'((g + 1) % LANES);
            SH_WAVE_SHR: begin
               oor = (g == 0);
               idx = IDX_W'((g + LANES - 1) % LANES);
            end
            SH_WAVE_ROR:
               idx = IDX_W'((g + LANES - 1) % LANES);
            SH_MIRROR:
               idx = IDX_W'(BASE + ROW_LANES - 1 - I);
            SH_HALF_MIRR:
               idx = IDX_W'(g ^ (ROW_LANES / 2 - 1));
            SH_BCAST_ROW: begin
               if (R == 0) skip = 1'b1;
               else        idx  = IDX_W'((BASE + LANES - 1) % LANES);
            end
            SH_BCAST_WAVE: begin
               if (R < 2) skip = 1'b1;
               else       idx  = IDX_W'(2 * ROW_LANES - 1);
            end
            default:
               oor = 1'b1;
         endcase
      end

      assign src_idx[g*IDX_W +: IDX_W] = idx;
      assign src_oor[g]                = oor;
      assign keep_old[g]               = skip;
   end

endmodule

// File: rtl/lane_pick.sv
module lane_pick #(
   parameter int DATA_W     = 32,
   parameter int ROWS       = 4,
   parameter int ROW_LANES  = 16,
   parameter int BANK_LANES = 4,
   localparam int LANES     = ROWS * ROW_LANES,
   localparam int BANKS     = ROW_LANES / BANK_LANES,
   localparam int IDX_W     = $clog2(LANES)
) (
   input  logic [LANES*DATA_W-1:0] src_vec,
   input  logic [LANES*DATA_W-1:0] old_vec,
   input  logic [LANES-1:0]        lane_valid,
   input  logic [LANES*IDX_W-1:0]  src_idx,
   input  logic [LANES-1:0]        src_oor,
   input  logic [LANES-1:0]        keep_old,
   input  logic [ROWS-1:0]         row_mask,
   input  logic [BANKS-1:0]        bank_mask,
   input  logic                    bound_zero,
   output logic [LANES*DATA_W-1:0] next_vec
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int R = g / ROW_LANES;
      localparam int B = (g % ROW_LANES) / BANK_LANES;

      logic [IDX_W-1:0]  s;
      logic [DATA_W-1:0] oldv;
      logic              enabled;
      logic              usable;

      assign s       = src_idx[g*IDX_W +: IDX_W];
      assign oldv    = old_vec[g*DATA_W +: DATA_W];
      assign enabled = row_mask[R] & bank_mask[B] & ~keep_old[g];
      assign usable  = ~src_oor[g] & lane_valid[s];

      always_comb begin
         if (!enabled)
            next_vec[g*DATA_W +: DATA_W] = oldv;
         else if (usable)
            next_vec[g*DATA_W +: DATA_W] = src_vec[s*DATA_W +: DATA_W];
         else if (bound_zero)
            next_vec[g*DATA_W +: DATA_W] = '0;
         else
            next_vec[g*DATA_W +: DATA_W] = oldv;
      end
   end

endmodule

// File: rtl/lane_shuffler.sv
module lane_shuffler #(
   parameter int DATA_W     = 32,
   parameter int ROWS       = 4,
   parameter int ROW_LANES  = 16,
   parameter int BANK_LANES = 4,
   parameter int ARG_W      = 8,
   localparam int LANES     = ROWS * ROW_LANES,
   localparam int BANKS     = ROW_LANES / BANK_LANES,
   localparam int IDX_W     = $clog2(LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [3:0]              mode,
   input  logic [ARG_W-1:0]        arg,
   input  logic [ROWS-1:0]         row_mask,
   input  logic [BANKS-1:0]        bank_mask,
   input  logic                    bound_zero,
   input  logic [LANES-1:0]        lane_valid,
   input  logic [LANES*DATA_W-1:0] src_vec,
   input  logic [LANES*DATA_W-1:0] old_vec,
   output logic                    done,
   output logic [LANES*DATA_W-1:0] result
);

   if (ROWS < 3)
      $error("lane_shuffler: the wave broadcast needs at least three rows");
   if (ROW_LANES < 4 || (ROW_LANES & (ROW_LANES - 1)) != 0)
      $error("lane_shuffler: ROW_LANES must be a power of two of at least 4");
   if (BANK_LANES < 2 || (ROW_LANES % BANK_LANES) != 0 || (BANK_LANES & (BANK_LANES - 1)) != 0)
      $error("lane_shuffler: BANK_LANES must be a power of two dividing ROW_LANES");
   if (ARG_W < $clog2(ROW_LANES) || ARG_W < BANK_LANES * $clog2(BANK_LANES))
      $error("lane_shuffler: ARG_W too narrow for shift amount or quad selectors");

   logic [LANES*IDX_W-1:0]  src_idx;
   logic [LANES-1:0]        src_oor;
   logic [LANES-1:0]        keep_old;
   logic [LANES*DATA_W-1:0] next_vec;

   lane_src_calc #(
      .ROWS(ROWS), .ROW_LANES(ROW_LANES), .BANK_LANES(BANK_LANES), .ARG_W(ARG_W)
   ) u_src (
      .mode(mode), .arg(arg),
      .src_idx(src_idx), .src_oor(src_oor), .keep_old(keep_old)
   );

   lane_pick #(
      .DATA_W(DATA_W), .ROWS(ROWS), .ROW_LANES(ROW_LANES), .BANK_LANES(BANK_LANES)
   ) u_pick (
      .src_vec(src_vec), .old_vec(old_vec), .lane_valid(lane_valid),
      .src_idx(src_idx), .src_oor(src_oor), .keep_old(keep_old),
      .row_mask(row_mask), .bank_mask(bank_mask), .bound_zero(bound_zero),
      .next_vec(next_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= start;
         if (start) result <= next_vec;
      end
   end

endmodule

// File: rtl/lane_shuf_chk.sv
module lane_shuf_chk
   import lane_shuf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ROWS       = 4,
   parameter int ROW_LANES  = 16,
   parameter int BANK_LANES = 4,
   parameter int ARG_W      = 8,
   localparam int LANES     = ROWS * ROW_LANES,
   localparam int BANKS     = ROW_LANES / BANK_LANES
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic [3:0]              mode,
   input logic [ARG_W-1:0]        arg,
   input logic [ROWS-1:0]         row_mask,
   input logic [BANKS-1:0]        bank_mask,
   input logic                    bound_zero,
   input logic [LANES-1:0]        lane_valid,
   input logic [LANES*DATA_W-1:0] src_vec,
   input logic [LANES*DATA_W-1:0] old_vec,
   input logic                    done,
   input logic [LANES*DATA_W-1:0] result
);
   localparam int TOP = LANES - 1;

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done); // R1
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done); // R1
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(result)); // R1

   for (genvar g = 0; g < LANES; g++) begin : g_mask
      localparam int R = g / ROW_LANES;
      localparam int B = (g % ROW_LANES) / BANK_LANES;
      AST_MASKED_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
         start && !(row_mask[R] && bank_mask[B])
         |=> result[g*DATA_W +: DATA_W] == $past(old_vec[g*DATA_W +: DATA_W])); // R3
   end

   AST_QPERM_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      start && mode == SH_QPERM && row_mask[0] && bank_mask[0] && lane_valid[arg[1:0]]
      |=> result[0 +: DATA_W] == $past(src_vec[arg[1:0]*DATA_W +: DATA_W])); // R4
   AST_BCAST_ROW0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      start && mode == SH_BCAST_ROW
      |=> result[0 +: DATA_W] == $past(old_vec[0 +: DATA_W])); // R9
   AST_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start && mode == SH_WAVE_SHL && bound_zero && row_mask[ROWS-1] && bank_mask[BANKS-1]
      |=> result[TOP*DATA_W +: DATA_W] == '0); // R10

endmodule

bind lane_shuffler lane_shuf_chk #(
   .DATA_W(DATA_W), .ROWS(ROWS), .ROW_LANES(ROW_LANES),
   .BANK_LANES(BANK_LANES), .ARG_W(ARG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .arg(arg),
   .row_mask(row_mask), .bank_mask(bank_mask), .bound_zero(bound_zero),
   .lane_valid(lane_valid), .src_vec(src_vec), .old_vec(old_vec),
   .done(done), .result(result)
);

// File: tb/tb_lane_shuffler.sv
`timescale 1ns/100ps
module tb_lane_shuffler;
   localparam int W = 32;
   localparam int N = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [3:0]      mode = '0;
   logic [7:0]      arg = '0;
   logic [3:0]      row_mask = 4'hF;
   logic [3:0]      bank_mask = 4'hF;
   logic            bound_zero = 1'b0;
   logic [N-1:0]    lane_valid = '1;
   logic [N*W-1:0]  src_vec = '0;
   logic [N*W-1:0]  old_vec = '0;
   logic            done;
   logic [N*W-1:0]  result;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   lane_shuffler dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .arg(arg),
      .row_mask(row_mask), .bank_mask(bank_mask), .bound_zero(bound_zero),
      .lane_valid(lane_valid), .src_vec(src_vec), .old_vec(old_vec),
      .done(done), .result(result)
   );

   function automatic logic [W-1:0] src_of(int l);
      return src_vec[l*W +: W];
   endfunction
   function automatic logic [W-1:0] old_of(int l);
      return old_vec[l*W +: W];
   endfunction

   // Expected lane value written from the requirement text
   function automatic logic [W-1:0] model(int l);
      int r = l / 16;
      int i = l % 16;
      int b = i / 4;
      int n = int'(arg[3:0]);
      int s = l;
      bit oor = 1'b0;
      bit skip = 1'b0;
      case (mode)
         4'd0: s = (l / 4) * 4 + ((int'(arg) >> (2 * (l % 4))) & 3);
         4'd1: if (i + n > 15) oor = 1; else s = r * 16 + i + n;
         4'd2: if (i < n) oor = 1; else s = r * 16 + i - n;
         4'd3: s = r * 16 + ((i - n + 16) % 16);
         4'd4: if (l == 63) oor = 1; else s = l + 1;
         4'd5: s = (l + 1) % 64;
         4'd6: if (l == 0) oor = 1; else s = l - 1;
         4'd7: s = (l + 63) % 64;
         4'd8: s = r * 16 + 15 - i;
         4'd9: s = r * 16 + ((i < 8) ? (7 - i) : (23 - i));
         4'd10: if (r == 0) skip = 1; else s = r * 16 - 1;
         4'd11: if (r < 2) skip = 1; else s = 31;
         default: oor = 1;
      endcase
      if (!row_mask[r] || !bank_mask[b] || skip) return old_of(l);
      if (oor || !lane_valid[s]) return bound_zero ? '0 : old_of(l);
      return src_of(s);
   endfunction

   task automatic fill(input logic [7:0] seed);
      for (int l = 0; l < N; l++) begin
         src_vec[l*W +: W] = {8'hC5, seed, 8'h5A, 8'(l)};
         old_vec[l*W +: W] = {8'h0D, 8'hD0, seed, 8'(l)};
      end
   endtask

   task automatic run_and_check(input string req, input string what);
      logic [N*W-1:0] exp;
      int bad = -1;
      for (int l = 0; l < N; l++) exp[l*W +: W] = model(l);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      checks++;
      if (done !== 1'b1) begin
         fails++;
         $display("FAIL %s %s: done=%0b expected 1", req, what, done);
      end
      checks++;
      for (int l = 0; l < N; l++)
         if (bad < 0 && result[l*W +: W] !== exp[l*W +: W]) bad = l;
      if (bad >= 0) begin
         fails++;
         $display("FAIL %s %s: lane %0d got %h expected %h", req, what, bad,
                  result[bad*W +: W], exp[bad*W +: W]);
      end
   endtask

   task automatic t_reset();
      checks++;
      if (done !== 1'b0 || result !== '0) begin
         fails++;
         $display("FAIL R2 reset: done=%0b result_lane0=%h expected 0/0", done, result[W-1:0]);
      end
   endtask

   task automatic t_handshake();
      logic [N*W-1:0] held;
      fill(8'h11); mode = 4'd5; bound_zero = 0;
      run_and_check("R1", "capture");
      held = result;
      fill(8'h22); mode = 4'd8;
      @(negedge clk);
      checks++;
      if (done !== 1'b0) begin
         fails++;
         $display("FAIL R1 done pulse: done=%0b expected 0", done);
      end
      repeat (3) @(negedge clk);
      checks++;
      if (result !== held) begin
         fails++;
         $display("FAIL R1 hold: lane0 %h expected %h", result[W-1:0], held[W-1:0]);
      end
   endtask

   task automatic t_qperm();
      fill(8'h31); mode = 4'd0;
      arg = 8'b00_01_10_11; run_and_check("R4", "qperm reverse");
      arg = 8'b10_10_10_10; run_and_check("R4", "qperm splat");
      arg = 8'b11_00_01_10; run_and_check("R4", "qperm mix");
   endtask

   task automatic t_row_shift();
      fill(8'h41);
      for (int bz = 0; bz < 2; bz++) begin
         bound_zero = bz[0];
         mode = 4'd1; arg = 8'd1;  run_and_check("R5", "row shl 1");
         mode = 4'd1; arg = 8'd15; run_and_check("R5", "row shl 15");
         mode = 4'd2; arg = 8'd5;  run_and_check("R5", "row shr 5");
         mode = 4'd3; arg = 8'd7;  run_and_check("R6", "row ror 7");
         mode = 4'd3; arg = 8'd15; run_and_check("R6", "row ror 15");
      end
      bound_zero = 0;
   endtask

   task automatic t_wave();
      fill(8'h51); arg = 8'h00;
      for (int bz = 0; bz < 2; bz++) begin
         bound_zero = bz[0];
         for (int c = 4; c < 8; c++) begin
            mode = 4'(c);
            run_and_check("R7", $sformatf("wave code %0d bz %0d", c, bz));
         end
      end
      bound_zero = 0;
   endtask

   task automatic t_mirror();
      fill(8'h61);
      mode = 4'd8; run_and_check("R8", "row mirror");
      mode = 4'd9; run_and_check("R8", "half mirror");
   endtask

   task automatic t_bcast();
      fill(8'h71);
      bound_zero = 1;
      mode = 4'd10; run_and_check("R9", "bcast row");
      mode = 4'd11; run_and_check("R9", "bcast wave");
      lane_valid = '1; lane_valid[31] = 1'b0;
      mode = 4'd11; run_and_check("R9", "bcast wave invalid source");
      lane_valid = '1; bound_zero = 0;
   endtask

   task automatic t_masks();
      fill(8'h81);
      bound_zero = 1;
      row_mask = 4'b1010; bank_mask = 4'hF; mode = 4'd4;
      run_and_check("R3", "row mask");
      row_mask = 4'hF; bank_mask = 4'b0110; mode = 4'd10;
      run_and_check("R3", "bank mask");
      row_mask = 4'b0111; bank_mask = 4'b1011; mode = 4'd12;
      run_and_check("R3", "both masks reserved code");
      row_mask = 4'hF; bank_mask = 4'hF; bound_zero = 0;
   endtask

   task automatic t_bounds();
      fill(8'h91);
      mode = 4'd14; bound_zero = 1; run_and_check("R10", "reserved code zero");
      bound_zero = 0;               run_and_check("R10", "reserved code keep");
      // destination lane 10 valid, its source lane 11 invalid; lane 21 invalid but its source 22 valid
      lane_valid = '1; lane_valid[11] = 1'b0; lane_valid[21] = 1'b0;
      mode = 4'd1; arg = 8'd1; bound_zero = 1;
      run_and_check("R11", "validity follows source");
      checks++;
      if (result[10*W +: W] !== '0 || result[21*W +: W] !== src_of(22)) begin
         fails++;
         $display("FAIL R11 lanes 10/21: got %h/%h expected 0/%h",
                  result[10*W +: W], result[21*W +: W], src_of(22));
      end
      lane_valid = 64'h5A5A_F0F0_3C3C_9999; mode = 4'd7; bound_zero = 0;
      run_and_check("R10", "sparse valid keep");
      lane_valid = '1; bound_zero = 0;
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_handshake();
      t_qperm();
      t_row_shift();
      t_wave();
      t_mirror();
      t_bcast();
      t_masks();
      t_bounds();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule